// File: doc/BRIEF.md
# Thermometer Scratchpad and Alarm Unit

This block is the register file of a digital temperature sensor. It holds eight byte-wide locations. Two of them hold the most recent conversion result. Three hold user settings: an upper whole-degree limit, a lower whole-degree limit, and a resolution selector. The last three are fixed constants. A conversion result arrives on a 16-bit input with a one-cycle strobe. The block stores that result with the bits below the selected resolution cleared. It then decides whether the new temperature lies outside the two limits, and keeps that verdict until the next result arrives.

The three user bytes have a backup copy, which is modelled as plain registers. A copy strobe saves the current user bytes into the backup. A recall strobe loads the backup back into the scratchpad. Reset loads the backup defaults into the scratchpad. A bus front end uses the byte write port and the combinational read port. A converter supplies results and takes the resolution code from the output port.

Top module: `thermo_scratchpad`

## Requirements
- R1: After reset, addresses 0 to 7 read 50h, 05h, the upper-limit default, the lower-limit default, the configuration byte of the default resolution, FFh, 0Ch and 10h. The alarm output is 0.
- R2: A write to address 2 (upper limit) or address 3 (lower limit) stores the whole byte. A write to address 4 stores only data bits 6:5 as the resolution code. Address 4 always reads bit 7 as 0 and bits 4:0 as 1, and the resolution output follows the stored code.
- R3: Writes to addresses 0, 1, 5, 6 and 7 change nothing that can be read.
- R4: A conversion strobe stores the input value in addresses 0 (low byte) and 1 (high byte). Resolution codes 11, 10, 01 and 00 mean 12, 11, 10 and 9 bits, and they clear the lowest 0, 1, 2 or 3 bits of the stored value.
- R5: One clock after a conversion strobe, the alarm output is 1 if the signed integer part (bits 11:4) of the result is greater than or equal to the signed upper limit, or less than or equal to the signed lower limit. Otherwise the alarm output is 0.
- R6: The alarm output holds its value between conversion strobes, whatever is written to the limits in the meantime.
- R7: The recall strobe loads addresses 2 to 4 from the backup. In the same cycle, recall takes priority over a write to those addresses.
- R8: When a conversion strobe and a write to address 2, 3 or 4 fall in the same cycle, the conversion uses the limits and resolution held before that clock edge.
- R9: The copy strobe saves addresses 2 to 4 into the backup. When it coincides with a write to those addresses, the backup receives the values held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Byte write address |
| wr_data | input | 8 | Byte write data |
| rd_addr | input | 3 | Byte read address |
| rd_data | output | 8 | Combinational read data |
| conv_valid | input | 1 | New conversion result strobe |
| conv_data | input | 16 | Conversion result, two's complement, 1/16 degree units |
| copy_req | input | 1 | Save user bytes into the backup |
| recall_req | input | 1 | Reload user bytes from the backup |
| alarm | output | 1 | Sticky out-of-limits flag |
| resolution | output | 2 | Current resolution code |

## Verification
The functions most likely to collide are a conversion and a user-setting write in the same cycle. Both act on the same clock edge, and the alarm verdict and the masking depend on the settings. The bench drives a conversion strobe together with a write that moves the upper limit above the sample, and separately together with a resolution change. It then judges the alarm and the stored low byte against the settings held before that edge. A follow-up conversion of the same value must show the new settings in effect. Recall against a write, and copy against a write, are provoked the same way and judged by reading the bytes back after a later recall.

// File: rtl/thermo_scratch_pkg.sv
package thermo_scratch_pkg;
   localparam int BYTE_W   = 8;
   localparam int NUM_LOC  = 8;
   localparam int ADDR_W   = $clog2(NUM_LOC);
   localparam int TEMP_W   = 2 * BYTE_W;
   localparam int FRAC_W   = 4;
   localparam int RES_W    = 2;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [RES_W-1:0]  res_t;

   typedef enum logic [ADDR_W-1:0] {
      LOC_TEMP_LO = 3'd0,
      LOC_TEMP_HI = 3'd1,
      LOC_UPPER   = 3'd2,
      LOC_LOWER   = 3'd3,
      LOC_CONFIG  = 3'd4,
      LOC_FIXED_A = 3'd5,
      LOC_FIXED_B = 3'd6,
      LOC_FIXED_C = 3'd7
   } loc_e;

   localparam byte_t FIXED_A_VAL = 8'hFF;
   localparam byte_t FIXED_B_VAL = 8'h0C;
   localparam byte_t FIXED_C_VAL = 8'h10;

   function automatic byte_t cfg_image(input res_t code);
      return {1'b0, code, 5'b11111};
   endfunction
endpackage

// File: rtl/thermo_limit_regs.sv
module thermo_limit_regs
   import thermo_scratch_pkg::*;
#(
   parameter byte_t UPPER_INIT = 8'h3C,
   parameter byte_t LOWER_INIT = 8'hF6,
   parameter res_t  RES_INIT   = 2'b11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  byte_t             wr_data,
   input  logic              copy_req,
   input  logic              recall_req,
   output byte_t             upper_o,
   output byte_t             lower_o,
   output res_t              res_o
);
   localparam int RES_LSB = 5;

   byte_t upper_q, lower_q, bk_upper_q, bk_lower_q;
   res_t  res_q, bk_res_q;

   logic wr_upper, wr_lower, wr_cfg;
   assign wr_upper = wr_en && (wr_addr == LOC_UPPER);
   assign wr_lower = wr_en && (wr_addr == LOC_LOWER);
   assign wr_cfg   = wr_en && (wr_addr == LOC_CONFIG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bk_upper_q <= UPPER_INIT;
         bk_lower_q <= LOWER_INIT;
         bk_res_q   <= RES_INIT;
      end else if (copy_req) begin
         bk_upper_q <= upper_q;
         bk_lower_q <= lower_q;
         bk_res_q   <= res_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upper_q <= UPPER_INIT;
         lower_q <= LOWER_INIT;
         res_q   <= RES_INIT;
      end else if (recall_req) begin
         upper_q <= bk_upper_q;
         lower_q <= bk_lower_q;
         res_q   <= bk_res_q;
      end else begin
         if (wr_upper) upper_q <= wr_data;
         if (wr_lower) lower_q <= wr_data;
         if (wr_cfg)   res_q   <= wr_data[RES_LSB +: RES_W];
      end
   end

   assign upper_o = upper_q;
   assign lower_o = lower_q;
   assign res_o   = res_q;

   assert_recall_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
      recall_req |=> (upper_q == $past(bk_upper_q)) && (lower_q == $past(bk_lower_q))
                     && (res_q == $past(bk_res_q)));

   assert_copy_old_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
      copy_req |=> (bk_upper_q == $past(upper_q)) && (bk_lower_q == $past(lower_q))
                   && (bk_res_q == $past(res_q)));

   assert_res_write_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!recall_req && !wr_cfg) |=> $stable(res_q));
endmodule

// File: rtl/thermo_sample_alarm.sv
module thermo_sample_alarm
   import thermo_scratch_pkg::*;
#(
   parameter logic [TEMP_W-1:0] TEMP_INIT = 16'h0550
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_valid,
   input  logic [TEMP_W-1:0] conv_data,
   input  res_t              res_i,
   input  byte_t             upper_i,
   input  byte_t             lower_i,
   output logic [TEMP_W-1:0] temp_o,
   output logic              alarm_o
);
   localparam res_t MAX_DROP = res_t'(3);

   if (TEMP_W < FRAC_W + BYTE_W) begin : g_width_bad
      $error("temperature word too narrow for integer part");
   end

   logic [TEMP_W-1:0] temp_q, masked;
   logic              alarm_q;
   res_t              drop;
   logic signed [BYTE_W-1:0] whole;
   logic              hit_upper, hit_lower;

   always_comb begin
      drop      = MAX_DROP - res_i;
      masked    = conv_data & ({TEMP_W{1'b1}} << drop);
      whole     = $signed(masked[FRAC_W +: BYTE_W]);
      hit_upper = whole >= $signed(upper_i);
      hit_lower = whole <= $signed(lower_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         temp_q  <= TEMP_INIT;
         alarm_q <= 1'b0;
      end else if (conv_valid) begin
         temp_q  <= masked;
         alarm_q <= hit_upper || hit_lower;
      end
   end

   assign temp_o  = temp_q;
   assign alarm_o = alarm_q;

   assert_mask_9bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_valid && res_i == 2'b00) |=> (temp_q[2:0] == 3'b000));

   assert_temp_readonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_valid |=> $stable(temp_q));

   assert_alarm_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_valid |=> $stable(alarm_q));

   assert_alarm_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_valid && ($signed(conv_data[FRAC_W +: BYTE_W]) >= $signed(upper_i))) |=> alarm_q);
endmodule

// File: rtl/thermo_scratchpad.sv
module thermo_scratchpad
   import thermo_scratch_pkg::*;
#(
   parameter logic [7:0]  UPPER_INIT = 8'h3C,
   parameter logic [7:0]  LOWER_INIT = 8'hF6,
   parameter logic [1:0]  RES_INIT   = 2'b11,
   parameter logic [15:0] TEMP_INIT  = 16'h0550
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  wr_addr,
   input  logic [7:0]  wr_data,
   input  logic [2:0]  rd_addr,
   output logic [7:0]  rd_data,
   input  logic        conv_valid,
   input  logic [15:0] conv_data,
   input  logic        copy_req,
   input  logic        recall_req,
   output logic        alarm,
   output logic [1:0]  resolution
);
   if (TEMP_W != 16 || ADDR_W != 3) begin : g_geom_bad
      $error("port widths do not match package geometry");
   end

   byte_t             upper, lower;
   res_t              res;
   logic [TEMP_W-1:0] temp;

   thermo_limit_regs #(
      .UPPER_INIT (UPPER_INIT),
      .LOWER_INIT (LOWER_INIT),
      .RES_INIT   (RES_INIT)
   ) limits_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .copy_req   (copy_req),
      .recall_req (recall_req),
      .upper_o    (upper),
      .lower_o    (lower),
      .res_o      (res)
   );

   thermo_sample_alarm #(
      .TEMP_INIT (TEMP_INIT)
   ) sample_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_valid (conv_valid),
      .conv_data  (conv_data),
      .res_i      (res),
      .upper_i    (upper),
      .lower_i    (lower),
      .temp_o     (temp),
      .alarm_o    (alarm)
   );

   always_comb begin
      unique case (loc_e'(rd_addr))
         LOC_TEMP_LO: rd_data = temp[0 +: BYTE_W];
         LOC_TEMP_HI: rd_data = temp[BYTE_W +: BYTE_W];
         LOC_UPPER:   rd_data = upper;
         LOC_LOWER:   rd_data = lower;
         LOC_CONFIG:  rd_data = cfg_image(res);
         LOC_FIXED_A: rd_data = FIXED_A_VAL;
         LOC_FIXED_B: rd_data = FIXED_B_VAL;
         default:     rd_data = FIXED_C_VAL;
      endcase
   end

   assign resolution = res;
endmodule

// File: tb/thermo_scratchpad_tb_top.sv
module thermo_scratchpad_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic        conv_valid = 1'b0;
   logic [15:0] conv_data = '0;
   logic        copy_req = 1'b0;
   logic        recall_req = 1'b0;
   logic        alarm;
   logic [1:0]  resolution;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   thermo_scratchpad dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .conv_valid(conv_valid), .conv_data(conv_data),
      .copy_req(copy_req), .recall_req(recall_req), .alarm(alarm), .resolution(resolution)
   );

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic cycle(input bit we, input logic [2:0] a, input logic [7:0] d,
                        input bit cv, input logic [15:0] cd, input bit cp, input bit rc);
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d;
      conv_valid = cv; conv_data = cd; copy_req = cp; recall_req = rc;
      @(negedge clk);
      wr_en = 1'b0; conv_valid = 1'b0; copy_req = 1'b0; recall_req = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      cycle(1'b1, a, d, 1'b0, 16'h0, 1'b0, 1'b0);
   endtask

   task automatic conv(input logic [15:0] v);
      cycle(1'b0, 3'd0, 8'h0, 1'b1, v, 1'b0, 1'b0);
   endtask

   task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
      rd_addr = a;
      #1;
      check(req, int'(rd_data), int'(exp));
   endtask

   task automatic t_reset();
      rd_check("R1 byte0", 3'd0, 8'h50);
      rd_check("R1 byte1", 3'd1, 8'h05);
      rd_check("R1 upper", 3'd2, 8'h3C);
      rd_check("R1 lower", 3'd3, 8'hF6);
      rd_check("R1 config", 3'd4, 8'h7F);
      rd_check("R1 fixed5", 3'd5, 8'hFF);
      rd_check("R1 fixed6", 3'd6, 8'h0C);
      rd_check("R1 fixed7", 3'd7, 8'h10);
      check("R1 alarm", int'(alarm), 0);
   endtask

   task automatic t_user_writes();
      wr(3'd2, 8'h19);
      wr(3'd3, 8'hEC);
      rd_check("R2 upper", 3'd2, 8'h19);
      rd_check("R2 lower", 3'd3, 8'hEC);
      wr(3'd4, 8'h9A);
      rd_check("R2 config fixed bits", 3'd4, 8'h1F);
      check("R2 res out", int'(resolution), 0);
      wr(3'd4, 8'h40);
      rd_check("R2 config 11bit", 3'd4, 8'h5F);
      check("R2 res out 2", int'(resolution), 2);
      wr(3'd4, 8'h60);
      check("R2 res out 3", int'(resolution), 3);
   endtask

   task automatic t_readonly();
      for (int a = 0; a < 8; a++) begin
         if (a >= 2 && a <= 4) continue;
         wr(3'(a), 8'hAA);
      end
      rd_check("R3 byte0", 3'd0, 8'h50);
      rd_check("R3 byte1", 3'd1, 8'h05);
      rd_check("R3 fixed5", 3'd5, 8'hFF);
      rd_check("R3 fixed6", 3'd6, 8'h0C);
      rd_check("R3 fixed7", 3'd7, 8'h10);
   endtask

   task automatic t_masking();
      conv(16'h0191);
      rd_check("R4 12bit lo", 3'd0, 8'h91);
      rd_check("R4 12bit hi", 3'd1, 8'h01);
      wr(3'd4, 8'h40);
      conv(16'h0191);
      rd_check("R4 11bit lo", 3'd0, 8'h90);
      wr(3'd4, 8'h20);
      conv(16'h00A2);
      rd_check("R4 10bit lo", 3'd0, 8'hA0);
      wr(3'd4, 8'h00);
      conv(16'hFF5E);
      rd_check("R4 9bit lo", 3'd0, 8'h58);
      rd_check("R4 9bit hi", 3'd1, 8'hFF);
      wr(3'd4, 8'h60);
   endtask

   task automatic t_alarm();
      conv(16'h0191);
      check("R5 at upper limit", int'(alarm), 1);
      conv(16'h0180);
      check("R5 inside limits", int'(alarm), 0);
      conv(16'hFEC0);
      check("R5 at lower limit", int'(alarm), 1);
      repeat (4) @(negedge clk);
      wr(3'd2, 8'h7F);
      wr(3'd3, 8'h80);
      check("R6 held across limit writes", int'(alarm), 1);
      wr(3'd2, 8'h19);
      wr(3'd3, 8'hEC);
      conv(16'h0000);
      check("R6 cleared by inside sample", int'(alarm), 0);
      conv(16'hFE6F);
      check("R5 negative fraction below", int'(alarm), 1);
      conv(16'h0000);
   endtask

   task automatic t_backup();
      wr(3'd2, 8'h11);
      cycle(1'b0, 3'd0, 8'h0, 1'b0, 16'h0, 1'b1, 1'b0);
      wr(3'd2, 8'h22);
      cycle(1'b0, 3'd0, 8'h0, 1'b0, 16'h0, 1'b0, 1'b1);
      rd_check("R7 recall", 3'd2, 8'h11);
      cycle(1'b1, 3'd2, 8'h33, 1'b0, 16'h0, 1'b0, 1'b1);
      rd_check("R7 recall beats write", 3'd2, 8'h11);
      cycle(1'b1, 3'd2, 8'h44, 1'b0, 16'h0, 1'b1, 1'b0);
      rd_check("R9 write lands", 3'd2, 8'h44);
      cycle(1'b0, 3'd0, 8'h0, 1'b0, 16'h0, 1'b0, 1'b1);
      rd_check("R9 copy took old", 3'd2, 8'h11);
      wr(3'd2, 8'h19);
   endtask

   task automatic t_collision();
      conv(16'h0000);
      cycle(1'b1, 3'd2, 8'h7F, 1'b1, 16'h0191, 1'b0, 1'b0);
      check("R8 old upper used", int'(alarm), 1);
      conv(16'h0191);
      check("R8 new upper used next", int'(alarm), 0);
      cycle(1'b1, 3'd4, 8'h1F, 1'b1, 16'h0197, 1'b0, 1'b0);
      rd_check("R8 old resolution used", 3'd0, 8'h97);
      conv(16'h0197);
      rd_check("R8 new resolution next", 3'd0, 8'h90);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_user_writes();
      t_readonly();
      t_masking();
      t_alarm();
      t_backup();
      t_collision();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule